// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects eight interrupt request inputs and ranks the ones that are not masked by priority. When one of them may preempt the work currently in service, it raises a single interrupt output to the CPU. On an acknowledge pulse it marks the winning line as in service and returns an 8-bit vector on the read data bus. The vector is a programmed five-bit base followed by the three-bit line number.

The CPU programs the block through a small register port. The port has one address bit, a write strobe, a read strobe and 8-bit data. A write at address 0 with data bit 4 set starts a setup sequence. The later address-1 writes of that sequence depend on the first word. Once setup is complete, address-1 accesses reach the mask register. Address-0 writes with bit 4 clear are commands. They cover end-of-service (specific or not, with optional rotation), set priority, rotation in automatic end-of-service mode, special mask mode and the choice of register returned by address-0 reads.

Setup bits for cascading, buffered operation, vector spacing and nested variants are accepted and discarded. They have no effect.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, int_out is low, the mask reads 0x00, the request register reads 0x00, the vector base is 0, inputs are edge-sensitive, line 0 has the highest priority and line 7 the lowest, and address-0 reads return the request register.
- R2: A write at address 0 with bit 4 set starts setup and clears the mask, the in-service register and the priority rotation. In that word, bit 3 set selects level trigger, bit 1 set skips the third word, and bit 0 set requests a fourth word. The following address-1 writes fill the second word, then the third word if it is not skipped, then the fourth word if it was requested. Every address-1 write after that goes to the mask.
- R3: While ack is high, rdata carries the vector: bits 7-3 are bits 7-3 of the second setup word, and bits 2-0 are the number of the line being acknowledged.
- R4: Mask bit n set (address 1, read and write) keeps line n from raising int_out.
- R5: Outside special mask mode, a pending unmasked line raises int_out only if its priority is higher than that of every line in service. An acknowledge marks the highest-priority eligible line as in service.
- R6: An address-0 write with bits 4-3 = 00 is a command, and bits 7-5 select the operation. Code 001 clears the highest-priority in-service bit. Code 011 clears the in-service bit of the line named in bits 2-0.
- R7: Codes 101 and 111 do what 001 and 011 do, and also make the cleared line the lowest priority. Code 110 makes the line in bits 2-0 the lowest priority. Priority runs upward from the lowest line, wrapping around.
- R8: When bit 1 of the fourth setup word is set, an acknowledge does not set an in-service bit. Command code 100 turns on rotation in this mode, so that each acknowledged line becomes the lowest priority. Code 000 turns that rotation off.
- R9: In edge mode, a request is latched on a rising input and cleared by its acknowledge, and an input held high is not requested again. In level mode, the request follows the input, so a request that drops before acknowledge raises nothing.
- R10: An address-0 write with bits 4-3 = 01 and bits 6-5 = 11 enters special mask mode, and bits 6-5 = 10 leaves it. In that mode, any unmasked pending line that is not in service may be signalled, whatever lines are in service. A line still in service is never signalled.
- R11: In that same command, bits 1-0 = 10 make address-0 reads return the request register, 11 make them return the in-service register, and 0x leave the choice unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, qualifies rdata |
| wdata | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulse from the CPU, one cycle |
| rdata | output | 8 | Read data, or the vector while ack is high |
| int_out | output | 1 | Interrupt request to the CPU |

## Verification
The hardest states to reach are those where the priority order has been rotated and several lines are in service at once. From the ports these can only be built through sequences of acknowledges and commands. Each scenario task therefore steps through a known chain of pulses, acknowledges and end-of-service commands. It then raises two lines at once, and the choice of winner between them tells the current lowest-priority line apart from the other candidates. Special mask mode is reached with a lower line held pending behind one in service, so that entering the mode is what releases it. The same line is then re-raised while it is still in service.

// File: rtl/irqc_pkg.sv
// Shared constants, types and priority helpers for the interrupt controller.
// Assumes a power-of-two line count so that levels wrap with plain arithmetic.
package irqc_pkg;
    localparam int LVL_W  = 3;
    localparam int N_IRQ  = 2 ** LVL_W;
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - LVL_W;

    typedef enum logic [1:0] {ST_READY, ST_W2, ST_W3, ST_W4} init_st_t;

    // Returns {found, level} of the highest-priority set bit; priority starts just above 'low'.
    function automatic logic [LVL_W:0] pick_top(input logic [N_IRQ-1:0] v,
                                                input logic [LVL_W-1:0] low);
        logic [LVL_W-1:0] l;
        logic [LVL_W:0]   res;
        res = '0;
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            l = low + LVL_W'(k + 1);
            if (v[l]) res = {1'b1, l};
        end
        return res;
    endfunction

    // Rank of a level, 0 being the highest priority.
    function automatic logic [LVL_W-1:0] rank_of(input logic [LVL_W-1:0] lvl,
                                                 input logic [LVL_W-1:0] low);
        logic [LVL_W-1:0] r;
        r = lvl - low - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irqc_req.sv
// Request register: one latch per line, edge- or level-sensitive.
// Assumes irq_in is synchronous to clk. A new edge wins over a same-cycle acknowledge clear.
module irqc_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Track the input and update the request bit of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                irr[i]    <= 1'b0;
            end else begin
                prev_q[i] <= irq_in[i];
                if (clr_all)                         irr[i] <= 1'b0;
                else if (level_mode)                 irr[i] <= irq_in[i];
                else if (irq_in[i] && !prev_q[i])    irr[i] <= 1'b1;
                else if (ack_clr[i])                 irr[i] <= 1'b0;
            end
        end
    end

    // R9
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !clr_all && (ack_clr & ~(irq_in & ~prev_q)) != '0)
        |=> (($past(ack_clr) & ~$past(irq_in & ~prev_q)) & irr) == '0);
endmodule

// File: rtl/irqc_regs.sv
// Register port: setup sequencer, mask, mode bits and command decode.
// Assumes wr_en is a one-cycle strobe. Commands are taken only after setup completes.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              setup_o,
    output logic              level_mode,
    output logic              aeoi,
    output logic              rot_aeoi,
    output logic              smm,
    output logic              rd_isr,
    output logic [BASE_W-1:0] base,
    output logic [N_IRQ-1:0]  imr,
    output logic              eoi_o,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic              setpri_o,
    output logic [LVL_W-1:0]  cmd_lvl
);
    init_st_t st;
    logic     single_q, want4_q;
    logic     is_cmd2, is_cmd3;

    // Decode the kind of address-0 write.
    always_comb begin
        setup_o = wr_en && !addr && wdata[4];
        is_cmd2 = wr_en && !addr && (wdata[4:3] == 2'b00) && (st == ST_READY);
        is_cmd3 = wr_en && !addr && (wdata[4:3] == 2'b01) && (st == ST_READY);
    end

    // Operation command fields go straight to the in-service logic.
    always_comb begin
        eoi_o        = is_cmd2 && wdata[5];
        eoi_specific = wdata[6];
        eoi_rotate   = wdata[7];
        setpri_o     = is_cmd2 && (wdata[7:5] == 3'b110);
        cmd_lvl      = wdata[LVL_W-1:0];
    end

    // Setup sequencer and programmable state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_READY; single_q <= 1'b1; want4_q <= 1'b0;
            level_mode <= 1'b0; aeoi <= 1'b0; rot_aeoi <= 1'b0;
            smm <= 1'b0; rd_isr <= 1'b0; base <= '0; imr <= '0;
        end else if (setup_o) begin
            st <= ST_W2; level_mode <= wdata[3];
            single_q <= wdata[1]; want4_q <= wdata[0];
            aeoi <= 1'b0; rot_aeoi <= 1'b0; smm <= 1'b0; rd_isr <= 1'b0; imr <= '0;
        end else if (wr_en && addr) begin
            unique case (st)
                ST_W2: begin
                    base <= wdata[DATA_W-1:LVL_W];
                    st   <= !single_q ? ST_W3 : (want4_q ? ST_W4 : ST_READY);
                end
                ST_W3:    st <= want4_q ? ST_W4 : ST_READY;
                ST_W4: begin
                    aeoi <= wdata[1];
                    st   <= ST_READY;
                end
                default:  imr <= wdata;
            endcase
        end else if (is_cmd2) begin
            if (wdata[6:5] == 2'b00) rot_aeoi <= wdata[7];
        end else if (is_cmd3) begin
            if (wdata[6]) smm    <= wdata[5];
            if (wdata[1]) rd_isr <= wdata[0];
        end
    end

    // R2
    skip_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_W2 && wr_en && addr && !setup_o && single_q) |=> (st != ST_W3));
endmodule

// File: rtl/irqc_prio.sv
// Priority resolver: picks the winning request and decides whether it may interrupt.
// Purely combinational; assumes the lowest-priority level is given explicitly.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [N_IRQ-1:0] irr,
    input  logic [N_IRQ-1:0] imr,
    input  logic [N_IRQ-1:0] isr,
    input  logic [LVL_W-1:0] low_lvl,
    input  logic             smm,
    output logic             eligible,
    output logic [LVL_W-1:0] win_lvl,
    output logic             isr_any,
    output logic [LVL_W-1:0] isr_top
);
    logic [N_IRQ-1:0] pend;
    logic             win_found;

    // Rank pending lines and in-service lines, then compare.
    always_comb begin
        pend = smm ? (irr & ~imr & ~isr) : (irr & ~imr);
        {win_found, win_lvl} = pick_top(pend, low_lvl);
        {isr_any, isr_top}   = pick_top(isr, low_lvl);
        eligible = win_found &&
                   (smm || !isr_any || (rank_of(win_lvl, low_lvl) < rank_of(isr_top, low_lvl)));
    end
endmodule

// File: rtl/irq_ctrl8.sv
// Eight-line programmable interrupt controller top level.
// Holds the in-service register and priority rotation; assumes ack is a one-cycle pulse.
module irq_ctrl8
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              int_out
);
    logic              setup, level_mode, aeoi, rot_aeoi, smm, rd_isr;
    logic [BASE_W-1:0] base;
    logic [N_IRQ-1:0]  imr, irr, isr, ack_clr;
    logic              eoi, eoi_specific, eoi_rotate, setpri;
    logic [LVL_W-1:0]  cmd_lvl, low_lvl, win_lvl, isr_top, eoi_tgt;
    logic              eligible, isr_any, take;

    irqc_regs u_regs (
        .clk, .rst_n, .addr, .wr_en, .wdata,
        .setup_o(setup), .level_mode, .aeoi, .rot_aeoi, .smm, .rd_isr, .base, .imr,
        .eoi_o(eoi), .eoi_specific, .eoi_rotate, .setpri_o(setpri), .cmd_lvl
    );

    irqc_req #(.N(N_IRQ)) u_req (
        .clk, .rst_n, .clr_all(setup), .level_mode, .irq_in, .ack_clr, .irr
    );

    irqc_prio u_prio (
        .irr, .imr, .isr, .low_lvl, .smm,
        .eligible, .win_lvl, .isr_any, .isr_top
    );

    // Acknowledge qualification and end-of-service target.
    always_comb begin
        take    = ack && eligible;
        ack_clr = take ? (N_IRQ'(1) << win_lvl) : '0;
        eoi_tgt = eoi_specific ? cmd_lvl : isr_top;
        int_out = eligible;
    end

    // In-service register and lowest-priority level.
    always_ff @(posedge clk) begin
        if (!rst_n || setup) begin
            isr     <= '0;
            low_lvl <= LVL_W'(N_IRQ - 1);
        end else begin
            if (eoi && (eoi_specific || isr_any)) begin
                isr[eoi_tgt] <= 1'b0;
                if (eoi_rotate) low_lvl <= eoi_tgt;
            end
            if (setpri) low_lvl <= cmd_lvl;
            if (take && !aeoi) isr[win_lvl] <= 1'b1;
            if (take && aeoi && rot_aeoi) low_lvl <= win_lvl;
        end
    end

    // Read mux: vector while acknowledging, else the selected register.
    always_comb begin
        if (ack)         rdata = {base, win_lvl};
        else if (!rd_en) rdata = '0;
        else if (addr)   rdata = imr;
        else if (rd_isr) rdata = isr;
        else             rdata = irr;
    end

    // R10
    no_resignal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !isr[win_lvl]);
    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !imr[win_lvl]);
    // R8
    aeoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && aeoi && !eoi && !setup) |=> (isr == $past(isr)));
    // R5
    one_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);
endmodule

// File: tb/irq_ctrl8_bench.sv
`timescale 1ns/100ps
module irq_ctrl8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       int_out;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    irq_ctrl8 u_irq_ctrl8 (
        .clk, .rst_n, .irq_in, .addr, .wr_en, .rd_en, .wdata, .ack, .rdata, .int_out
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk); ack = 1'b1;
        #1 v = rdata;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk); irq_in = irq_in | m;
        @(negedge clk); irq_in = irq_in & ~m;
    endtask

    task automatic setup(input logic lvl, input logic auto_eoi);
        wr(0, 8'h13 | (8'(lvl) << 3));
        wr(1, 8'h08);
        wr(1, {6'b0, auto_eoi, 1'b1});
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        do_ack(v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 int_out", {7'b0, int_out}, 8'h00);
        rd(1, d); chk("R1 mask", d, 8'h00);
        rd(0, d); chk("R1 request reg", d, 8'h00);
        pulse(8'h81);
        ack_expect("R1 line0 highest, base 0", 8'h00);
        wr(0, 8'h20);
    endtask

    task automatic t_setup;
        logic [7:0] d;
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01); wr(1, 8'hA5);
        rd(1, d); chk("R2 cascade path reaches mask", d, 8'hA5);
        wr(0, 8'h12);
        rd(1, d); chk("R2 setup clears mask", d, 8'h00);
        wr(1, 8'h20); wr(1, 8'h3C);
        rd(1, d); chk("R2 single no fourth word", d, 8'h3C);
        pulse(8'h01);
        ack_expect("R3 vector base", 8'h20);
        wr(0, 8'h20);
    endtask

    task automatic t_basic;
        logic [7:0] d;
        setup(0, 0);
        pulse(8'h24);
        chk("R5 int raised", {7'b0, int_out}, 8'h01);
        ack_expect("R3 vector of line 2", 8'h0A);
        chk("R5 lower line waits", {7'b0, int_out}, 8'h00);
        wr(0, 8'h0B); rd(0, d); chk("R11 in-service read", d, 8'h04);
        wr(0, 8'h08); rd(0, d); chk("R11 selection kept", d, 8'h04);
        wr(0, 8'h0A); rd(0, d); chk("R11 request read", d, 8'h20);
        pulse(8'h02);
        chk("R5 higher line preempts", {7'b0, int_out}, 8'h01);
        ack_expect("R5 nested vector", 8'h09);
        wr(0, 8'h0B); rd(0, d); chk("R5 two in service", d, 8'h06);
        wr(0, 8'h20); rd(0, d); chk("R6 nonspecific clears top", d, 8'h04);
        wr(0, 8'h62); rd(0, d); chk("R6 specific clears line 2", d, 8'h00);
        ack_expect("R5 pending line 5 served", 8'h0D);
        wr(0, 8'h20); wr(0, 8'h0A);
        @(negedge clk); irq_in = 8'h08;
        @(negedge clk);
        ack_expect("R9 edge line 3", 8'h0B);
        wr(0, 8'h20);
        @(negedge clk);
        chk("R9 held edge input not re-requested", {7'b0, int_out}, 8'h00);
        irq_in = 8'h00;
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(1, 8'h10);
        rd(1, d); chk("R4 mask readback", d, 8'h10);
        pulse(8'h10);
        @(negedge clk);
        chk("R4 masked line silent", {7'b0, int_out}, 8'h00);
        wr(1, 8'h00);
        chk("R4 unmask releases", {7'b0, int_out}, 8'h01);
        ack_expect("R4 vector after unmask", 8'h0C);
        wr(0, 8'h20);
    endtask

    task automatic t_rotate;
        pulse(8'h01);
        ack_expect("R7 line 0", 8'h08);
        wr(0, 8'hA0);
        pulse(8'h81);
        ack_expect("R7 rotate nonspecific makes 0 lowest", 8'h0F);
        wr(0, 8'h20);
        ack_expect("R7 line 0 after", 8'h08);
        wr(0, 8'h20);
        wr(0, 8'hC3);
        pulse(8'h24);
        ack_expect("R7 set priority 3 lowest", 8'h0D);
        wr(0, 8'h20);
        ack_expect("R7 line 2 after", 8'h0A);
        wr(0, 8'h20);
        wr(0, 8'hC7);
        pulse(8'h10);
        ack_expect("R7 line 4", 8'h0C);
        wr(0, 8'hE4);
        pulse(8'h28);
        ack_expect("R7 rotate specific makes 4 lowest", 8'h0D);
        wr(0, 8'h20);
        ack_expect("R7 line 3 after", 8'h0B);
        wr(0, 8'h20);
        wr(0, 8'hC7);
    endtask

    task automatic t_level;
        setup(1, 0);
        @(negedge clk); irq_in = 8'h40;
        @(negedge clk);
        chk("R9 level request", {7'b0, int_out}, 8'h01);
        irq_in = 8'h00;
        @(negedge clk);
        chk("R9 level drop withdraws", {7'b0, int_out}, 8'h00);
        irq_in = 8'h40;
        @(negedge clk);
        ack_expect("R9 level vector", 8'h0E);
        chk("R9 in service blocks", {7'b0, int_out}, 8'h00);
        wr(0, 8'h20);
        chk("R9 level held re-requests", {7'b0, int_out}, 8'h01);
        irq_in = 8'h00;
        @(negedge clk);
        chk("R9 level released", {7'b0, int_out}, 8'h00);
    endtask

    task automatic t_aeoi;
        logic [7:0] d;
        setup(0, 1);
        pulse(8'h08);
        ack_expect("R8 auto vector", 8'h0B);
        wr(0, 8'h0B); rd(0, d); chk("R8 no in-service bit", d, 8'h00);
        wr(0, 8'h0A);
        wr(0, 8'h80);
        pulse(8'h08);
        ack_expect("R8 line 3", 8'h0B);
        pulse(8'h14);
        ack_expect("R8 rotation made 3 lowest", 8'h0C);
        wr(0, 8'h00);
        ack_expect("R8 leftover line 2", 8'h0A);
        pulse(8'h0A);
        ack_expect("R8 rotation off keeps 4 lowest", 8'h09);
        ack_expect("R8 line 3 last", 8'h0B);
    endtask

    task automatic t_smm;
        logic [7:0] d;
        setup(0, 0);
        pulse(8'h02);
        ack_expect("R10 line 1", 8'h09);
        pulse(8'h10);
        chk("R10 lower blocked normally", {7'b0, int_out}, 8'h00);
        wr(0, 8'h68);
        chk("R10 special mask releases lower", {7'b0, int_out}, 8'h01);
        ack_expect("R10 lower served", 8'h0C);
        pulse(8'h02);
        chk("R10 in-service line not signalled", {7'b0, int_out}, 8'h00);
        wr(0, 8'h0B); rd(0, d); chk("R10 both in service", d, 8'h12);
        wr(0, 8'h48);
        chk("R10 leave mode", {7'b0, int_out}, 8'h00);
        wr(0, 8'h61);
        chk("R10 line 1 eligible again", {7'b0, int_out}, 8'h01);
        ack_expect("R10 line 1 vector", 8'h09);
        wr(0, 8'h20); wr(0, 8'h20);
        rd(0, d); chk("R6 all cleared", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_basic();
        t_mask();
        t_rotate();
        t_level();
        t_aeoi();
        t_smm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule